// File: doc/BRIEF.md
# Chip-Enable-Strobed Bytewide Memory Controller

This controller turns one-at-a-time host requests (valid/ready handshake, read or write flag, 13-bit address, 8-bit write data) into access cycles on a bytewide parallel memory. The memory captures its address only on a falling chip-enable edge, so the controller drives a fresh chip-enable strobe for every request. Chip enable stays low for a fixed access window and then stays high for a fixed recovery (precharge) window before another strobe may begin. Output-enable, write-enable and the write-data driver are qualified by the low phase of chip enable.

All three timing windows are parameters counted in clock cycles. The access window is checked at elaboration against the longest low time the memory tolerates. A separate low-time counter in the datapath also ends any strobe that would reach that limit. Read data is captured from the memory bus in the last low cycle and handed back with a single-cycle response pulse. Writes finish inside their own strobe, and a following request of either kind needs no status polling.

Top module: `strobe_mem_ctrl`

## Requirements
- R1: After reset, memCeN, memOeN and memWeN are 1, memDoutEn and rspValid are 0, and reqReady is 1.
- R2: Each accepted request (reqValid and reqReady both 1 at a rising clock edge) causes exactly one falling edge of memCeN, on that same edge. memCeN then stays low for exactly ACCESS_CYC clock cycles.
- R3: memAddr carries the accepted request's address from the edge where memCeN falls and keeps it for the whole low phase. Changing reqAddr after acceptance has no effect on the access.
- R4: Between two strobes, memCeN stays high for at least PRECHARGE_CYC cycles. When a request is waiting, the high gap is exactly PRECHARGE_CYC cycles.
- R5: memCeN never stays low for more than MAX_LOW_CYC consecutive cycles. ACCESS_CYC greater than MAX_LOW_CYC is rejected at elaboration.
- R6: reqReady is 0 from the acceptance edge until the last precharge cycle, in which it returns to 1. reqReady is never 1 while memCeN is 0.
- R7: For a write (reqWrite = 1), memWeN is 0 and memDoutEn is 1 for exactly the cycles in which memCeN is 0. memDout carries the request's data, and memOeN stays 1.
- R8: For a read (reqWrite = 0), memOeN is 0 exactly while memCeN is 0, and memWeN stays 1. memDin is sampled on the last low cycle. rspValid is 1 for exactly one cycle, starting at the edge where memCeN rises (ACCESS_CYC edges after acceptance), with rspRdata holding the sampled byte.
- R9: A write produces no rspValid pulse. A read issued directly after a write to the same address returns the written byte.
- R10: The lowest address (0) and the highest address (8191) are both reachable and keep distinct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Controller can start a new strobe on the next edge |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 13 | Request byte address |
| reqWdata | input | 8 | Request write data |
| rspValid | output | 1 | One-cycle read response strobe |
| rspRdata | output | 8 | Read response data |
| memCeN | output | 1 | Memory chip enable, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memWeN | output | 1 | Memory write enable, active low |
| memAddr | output | 13 | Memory address bus |
| memDout | output | 8 | Data toward memory |
| memDoutEn | output | 1 | Drive enable for memDout |
| memDin | input | 8 | Data from memory |

## Verification
Two events can land in the same cycle: the last cycle of precharge and the acceptance of the next request. In that cycle the recovery window closes and a new chip-enable strobe opens. The bench provokes this by presenting the next request while the previous one is still precharging, so the handshake lands on the very edge that ends the recovery window. It then judges the result by measuring the chip-enable high gap as exactly PRECHARGE_CYC cycles and by checking that the read that follows a write returns the written byte. The read response pulse also falls in the first precharge cycle, and its position is checked against the acceptance edge.

// File: rtl/strobe_mem_pkg.sv
package strobe_mem_pkg;

  typedef enum logic [1:0] {
    PH_IDLE      = 2'd0,
    PH_ACCESS    = 2'd1,
    PH_PRECHARGE = 2'd2
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchReq;   // capture request and open a chip-enable strobe
    logic endAccess;  // close the strobe (and sample read data)
  } ctrlStrobe_t;

endpackage

// File: rtl/strobe_mem_ctrl_fsm.sv
module strobe_mem_ctrl_fsm
  import strobe_mem_pkg::*;
#(
  parameter int ACCESS_CYC    = 24,
  parameter int PRECHARGE_CYC = 18
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        lowLimitHit,
  output logic        reqReady,
  output ctrlStrobe_t strobe
);

  localparam int MAX_PHASE = (ACCESS_CYC > PRECHARGE_CYC) ? ACCESS_CYC : PRECHARGE_CYC;
  localparam int CNT_W     = $clog2(MAX_PHASE + 1);
  localparam logic [CNT_W-1:0] ACC_LAST = CNT_W'(ACCESS_CYC - 1);
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRECHARGE_CYC - 1);

  phase_t           phase;
  logic [CNT_W-1:0] phaseCnt;
  logic             accessLast;
  logic             prechLast;
  logic             accept;

  always_comb begin
    accessLast = (phase == PH_ACCESS) && ((phaseCnt == ACC_LAST) || lowLimitHit);
    prechLast  = (phase == PH_PRECHARGE) && (phaseCnt == PRE_LAST);
    reqReady   = (phase == PH_IDLE) || prechLast;
    accept     = reqValid && reqReady;
    strobe.latchReq  = accept;
    strobe.endAccess = accessLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      phaseCnt <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          phaseCnt <= '0;
          if (accept) phase <= PH_ACCESS;
        end
        PH_ACCESS: begin
          if (accessLast) begin
            phase    <= PH_PRECHARGE;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        PH_PRECHARGE: begin
          if (prechLast) begin
            phase    <= accept ? PH_ACCESS : PH_IDLE;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        default: begin
          phase    <= PH_IDLE;
          phaseCnt <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/strobe_mem_ctrl_dp.sv
module strobe_mem_ctrl_dp
  import strobe_mem_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int MAX_LOW_CYC = 2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic              lowLimitHit,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn
);

  localparam int LOW_W = $clog2(MAX_LOW_CYC + 1);
  localparam logic [LOW_W-1:0] LOW_LAST = LOW_W'(MAX_LOW_CYC - 1);

  logic              ceLow;
  logic              isWrite;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic [DATA_W-1:0] rdataReg;
  logic              rspReg;
  logic [LOW_W-1:0]  lowCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ceLow    <= 1'b0;
      isWrite  <= 1'b0;
      addrReg  <= '0;
      wdataReg <= '0;
      rdataReg <= '0;
      rspReg   <= 1'b0;
      lowCnt   <= '0;
    end else begin
      rspReg <= 1'b0;
      if (strobe.latchReq) begin
        ceLow    <= 1'b1;
        isWrite  <= reqWrite;
        addrReg  <= reqAddr;
        wdataReg <= reqWdata;
        lowCnt   <= '0;
      end else if (strobe.endAccess) begin
        ceLow <= 1'b0;
        if (!isWrite) begin
          rdataReg <= memDin;
          rspReg   <= 1'b1;
        end
      end else if (ceLow) begin
        lowCnt <= lowCnt + 1'b1;
      end
    end
  end

  always_comb begin
    lowLimitHit = ceLow && (lowCnt == LOW_LAST);
    memCeN      = ~ceLow;
    memOeN      = ~(ceLow && !isWrite);
    memWeN      = ~(ceLow && isWrite);
    memDoutEn   = ceLow && isWrite;
    memAddr     = addrReg;
    memDout     = wdataReg;
    rspValid    = rspReg;
    rspRdata    = rdataReg;
  end

endmodule

// File: rtl/strobe_mem_ctrl.sv
module strobe_mem_ctrl
  import strobe_mem_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int DATA_W        = 8,
  parameter int ACCESS_CYC    = 24,
  parameter int PRECHARGE_CYC = 18,
  parameter int MAX_LOW_CYC   = 2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  input  logic [DATA_W-1:0] memDin
);

  // Elaboration-time timing sanity (R5)
  if (ACCESS_CYC < 1 || PRECHARGE_CYC < 1) begin : g_badWindow
    $error("strobe_mem_ctrl: access and precharge windows must be at least one cycle");
  end
  if (ACCESS_CYC > MAX_LOW_CYC) begin : g_badLowLimit
    $error("strobe_mem_ctrl: ACCESS_CYC exceeds MAX_LOW_CYC");
  end

  ctrlStrobe_t strobe;
  logic        lowLimitHit;

  strobe_mem_ctrl_fsm #(
    .ACCESS_CYC   (ACCESS_CYC),
    .PRECHARGE_CYC(PRECHARGE_CYC)
  ) u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .lowLimitHit(lowLimitHit),
    .reqReady   (reqReady),
    .strobe     (strobe)
  );

  strobe_mem_ctrl_dp #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .MAX_LOW_CYC(MAX_LOW_CYC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqWrite   (reqWrite),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .memDin     (memDin),
    .lowLimitHit(lowLimitHit),
    .rspValid   (rspValid),
    .rspRdata   (rspRdata),
    .memCeN     (memCeN),
    .memOeN     (memOeN),
    .memWeN     (memWeN),
    .memAddr    (memAddr),
    .memDout    (memDout),
    .memDoutEn  (memDoutEn)
  );

endmodule

// File: rtl/strobe_mem_ctrl_chk.sv
module strobe_mem_ctrl_chk #(
  parameter int ADDR_W        = 13,
  parameter int PRECHARGE_CYC = 18,
  parameter int MAX_LOW_CYC   = 2000
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic              memCeN,
  input logic              memOeN,
  input logic              memWeN,
  input logic              memDoutEn,
  input logic [ADDR_W-1:0] memAddr
);

  logic [31:0] lowRun;
  logic [31:0] highRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowRun  <= '0;
      highRun <= 32'(PRECHARGE_CYC);
    end else begin
      lowRun <= memCeN ? '0 : lowRun + 1;
      if (!memCeN)                             highRun <= '0;
      else if (highRun < 32'(PRECHARGE_CYC))   highRun <= highRun + 1;
    end
  end

  assert_low_limit_R5: assert property (@(posedge clk) disable iff (!rstN)
    !memCeN |-> (lowRun < 32'(MAX_LOW_CYC)));

  assert_precharge_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memCeN) |-> (highRun >= 32'(PRECHARGE_CYC)));

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && !$past(memCeN)) |-> $stable(memAddr));

  assert_ready_only_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> memCeN);

  assert_we_in_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN || memDoutEn) |-> !memCeN);

  assert_oe_we_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN));

  assert_rsp_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

bind strobe_mem_ctrl strobe_mem_ctrl_chk #(
  .ADDR_W       (ADDR_W),
  .PRECHARGE_CYC(PRECHARGE_CYC),
  .MAX_LOW_CYC  (MAX_LOW_CYC)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .rspValid (rspValid),
  .memCeN   (memCeN),
  .memOeN   (memOeN),
  .memWeN   (memWeN),
  .memDoutEn(memDoutEn),
  .memAddr  (memAddr)
);

// File: tb/tb_strobe_mem_ctrl.sv
`timescale 1ns/1ps
module tb_strobe_mem_ctrl;

  localparam int ADDR_W = 13;
  localparam int DATA_W = 8;
  localparam int ACC    = 24;
  localparam int PRE    = 18;
  localparam int MAXLOW = 40;

  logic              clk = 1'b0;
  logic              rstN;
  logic              reqValid, reqReady, reqWrite;
  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqWdata;
  logic              rspValid;
  logic [DATA_W-1:0] rspRdata;
  logic              memCeN, memOeN, memWeN, memDoutEn;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memDout, memDin;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  strobe_mem_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACCESS_CYC(ACC),
    .PRECHARGE_CYC(PRE), .MAX_LOW_CYC(MAXLOW)
  ) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .memCeN(memCeN),
    .memOeN(memOeN), .memWeN(memWeN), .memAddr(memAddr),
    .memDout(memDout), .memDoutEn(memDoutEn), .memDin(memDin)
  );

  // Memory model: latches the address at the first low cycle of chip enable
  logic [DATA_W-1:0] memModel [0:(1<<ADDR_W)-1];
  logic [ADDR_W-1:0] latchA = '0;
  logic              prevCe = 1'b1;
  int lowRunM = 0, highRunM = 0, lastLow = 0, lastHigh = 0, falls = 0;
  bit seenLow = 0;

  assign memDin = (!memCeN && !memOeN) ? memModel[latchA] : '0;

  always @(posedge clk) begin
    if (!rstN) begin
      prevCe = 1'b1; lowRunM = 0; highRunM = 0; seenLow = 0;
    end else begin
      if (!memCeN) begin
        if (prevCe) begin latchA = memAddr; falls++; end
        if (!memWeN) memModel[latchA] = memDout;
        if (highRunM != 0) begin lastHigh = highRunM; highRunM = 0; end
        lowRunM++; seenLow = 1;
      end else begin
        if (lowRunM != 0) begin lastLow = lowRunM; lowRunM = 0; end
        if (seenLow) highRunM++;
      end
      prevCe = memCeN;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Runs one access; caller is at a negedge. Returns at negedge ACC+PRE after acceptance.
  task automatic doAccess(input bit wr, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] d, input bit expRsp,
                          input logic [DATA_W-1:0] expData);
    int lowCyc = 0, weBad = 0, oeBad = 0, addrBad = 0, rdyBad = 0, doutBad = 0;
    int rspCnt = 0, rspAt = -1, fallsBefore;
    logic [DATA_W-1:0] got = '0;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    fallsBefore = falls;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = ~a; reqWdata = ~d;   // perturb after acceptance (R3)
    for (int k = 1; k <= ACC + PRE; k++) begin
      if (k > 1) @(negedge clk);
      if (!memCeN) begin
        lowCyc++;
        if (memAddr != a) addrBad++;
        if (wr && (memWeN || !memDoutEn || !memOeN || memDout != d)) weBad++;
        if (!wr && (memOeN || !memWeN || memDoutEn)) oeBad++;
      end else if (!memWeN || !memOeN || memDoutEn) doutBad++;
      if ((k < ACC + PRE && reqReady) || (k == ACC + PRE && !reqReady)) rdyBad++;
      if (rspValid) begin rspCnt++; rspAt = k; got = rspRdata; end
    end
    check(falls == fallsBefore + 1, "R2 one strobe per request", falls - fallsBefore, 1);
    check(lowCyc == ACC, "R2 low window length", lowCyc, ACC);
    check(addrBad == 0, "R3 address held during strobe", addrBad, 0);
    check(rdyBad == 0, "R6 ready timing", rdyBad, 0);
    check(doutBad == 0, "R7 R8 enables outside strobe", doutBad, 0);
    check(lastLow <= MAXLOW, "R5 low limit", lastLow, MAXLOW);
    if (wr) begin
      check(weBad == 0, "R7 write strobe qualification", weBad, 0);
      check(rspCnt == 0, "R9 no response on write", rspCnt, 0);
    end else begin
      check(oeBad == 0, "R8 read strobe qualification", oeBad, 0);
      check(rspCnt == 1 && rspAt == ACC + 1, "R8 response position", rspAt, ACC + 1);
      if (expRsp) check(got == expData, "R8 read data", int'(got), int'(expData));
    end
  endtask

  task automatic t_reset();
    check(memCeN && memOeN && memWeN, "R1 strobes idle",
          {memCeN, memOeN, memWeN}, 3'b111);
    check(!memDoutEn && !rspValid, "R1 no drive no response",
          {memDoutEn, rspValid}, 0);
    check(reqReady, "R1 ready", reqReady, 1);
  endtask

  task automatic t_writeRead();
    doAccess(1'b1, 13'h0123, 8'h5A, 1'b0, '0);
    doAccess(1'b0, 13'h0123, 8'h00, 1'b1, 8'h5A);      // R9 read right after write
    check(lastHigh == PRE, "R4 back-to-back gap", lastHigh, PRE);
  endtask

  task automatic t_idleGap();
    for (int i = 0; i < 10; i++) @(negedge clk);
    doAccess(1'b1, 13'h0777, 8'hC3, 1'b0, '0);
    check(lastHigh >= PRE, "R4 gap after idle", lastHigh, PRE);
    doAccess(1'b0, 13'h0777, 8'h00, 1'b1, 8'hC3);
  endtask

  task automatic t_boundary();
    doAccess(1'b1, 13'h0000, 8'h11, 1'b0, '0);
    doAccess(1'b1, 13'h1FFF, 8'hEE, 1'b0, '0);
    doAccess(1'b0, 13'h0000, 8'h00, 1'b1, 8'h11);      // R10 lowest address
    doAccess(1'b0, 13'h1FFF, 8'h00, 1'b1, 8'hEE);      // R10 highest address
  endtask

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) memModel[i] = 8'(i * 7 + 3);
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0; reqWdata = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_writeRead();
    t_idleGap();
    t_boundary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5ns * 20000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule